// File: doc/BRIEF.md
# Two-Wire Target Front End for a Clock/Control Register Array

This block sits between a two-wire serial bus (open-drain clock and data lines) and a small clock/control register array of 26 byte locations. It watches the bus through synchronizers running on the system clock and recognises bus START, repeated START and STOP. It takes in the first byte after a START, compares its upper seven bits against a fixed identifier, and acknowledges when they match. The low bit of that byte selects a read or a write.

A write carries one word-address byte and then one data byte, which is stored in the array. After that the block stands by until the next START or STOP. A read streams bytes out of the array, most significant bit first. It starts at an internal pointer and keeps going for as long as the bus controller acknowledges each byte. The pointer is set by a word address, advances once per byte moved, wraps from location 19h back to 00h, and keeps its value from one transaction to the next. A random read is a dummy write that sets the pointer, then a repeated START with the read bit set.

The array itself is outside the block. The block presents a location, write data and a one-cycle write enable, and takes combinational read data back. On the bus side it has only a pull-low request for the data line.

Top module: `i2c_tgt_top`

## Requirements
- R1: A first byte after START whose upper seven bits equal 1101111 is acknowledged: the data line is pulled low during the ninth clock. Bit 0 of that byte selects a read when 1 and a write when 0.
- R2: A first byte with any other identifier gets no acknowledge. The block then pulls the line for no byte and writes nothing until the next START.
- R3: A write acknowledges the identifier, the word address and one data byte, and stores the data byte at the addressed location with exactly one write-enable pulse. Any further byte in the same transaction gets no acknowledge and is not stored.
- R4: A random read returns the contents of the location named by its dummy-write word address as the first byte.
- R5: After reset the pointer is 00h, so a read with no preceding word address starts at location 00h.
- R6: During a read, each byte acknowledged by the controller is followed by the byte at the next location, sent MSB first.
- R7: The pointer advances by one per data byte and goes from 19h to 00h.
- R8: A word address above 19h sets the pointer to 00h.
- R9: After a write stores its byte, the pointer stands at the next location, so a following current-address read starts there.
- R10: After a byte that the controller does not acknowledge, the block releases the data line for every further clock and does not advance the pointer again. The next read continues at the location after the last byte sent.
- R11: A START or STOP in any state abandons the byte in progress. A STOP releases the data line on the next cycle, and a START restarts identifier reception.
- R12: The data line is only ever pulled low or released: it is released during and after reset, and it changes only while the synchronized clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaDriveLow | output | 1 | 1 pulls the data line low, 0 releases it |
| regAddr | output | 5 | Array location (the pointer) |
| regWrData | output | 8 | Byte to store |
| regWrEn | output | 1 | One-cycle store strobe |
| regRdData | input | 8 | Contents of the location at regAddr |

## Verification
Two things happen in the same cycle at the end of a write: the data byte is stored and the pointer advances. The store must use the old location and the pointer must move only afterwards. The bench provokes this by writing one location and then doing a current-address read. The write must hit exactly the addressed location, and the read must return the following one. The same cycle also decides the wrap during a streamed read that crosses 19h, where advancing the pointer and fetching the next byte coincide. That case is judged on the order of the three returned bytes.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADDR,
    ST_WADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;     // sample data line into receive shifter
    logic countBit;    // bump bit counter
    logic clrBits;     // clear bit counter
    logic loadTx;      // load transmit shifter from array
    logic shiftTx;     // advance transmit shifter
    logic loadPtr;     // pointer from received word address
    logic incPtr;      // pointer plus one with wrap
    logic wrEn;        // store received byte
    logic sdaLowNext;  // requested pull-low for next cycle
  } dpCtrl_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= {STAGES{RESET_VAL}};
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];

endmodule

// File: rtl/i2c_tgt_datapath.sv
module i2c_tgt_datapath
  import i2c_tgt_pkg::*;
#(
  parameter int NUM_REGS    = 26,
  parameter int SYNC_STAGES = 2,
  parameter int ADDR_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtrl_t           ctrl,
  output logic              sclSync,
  output logic              sdaSync,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic              byteDone,
  output logic [7:0]        rxByte,
  output logic              txMsb,
  output logic              sdaDriveLow,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWrData,
  output logic              regWrEn,
  input  logic [7:0]        regRdData
);

  localparam logic [ADDR_W-1:0] LAST_LOC = ADDR_W'(NUM_REGS - 1);
  localparam logic [7:0]        LOC_LIMIT = 8'(NUM_REGS);

  logic              sclPrev, sdaPrev;
  logic [3:0]        bitCnt;
  logic [7:0]        txShift;
  logic [ADDR_W-1:0] ptr;
  logic              sdaLow;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sclSync (
    .clk(clk), .rstN(rstN), .din(sclIn), .dout(sclSync)
  );
  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sdaSync (
    .clk(clk), .rstN(rstN), .din(sdaIn), .dout(sdaSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclSync;
      sdaPrev <= sdaSync;
    end
  end

  assign sclRise  = sclSync & ~sclPrev;
  assign sclFall  = ~sclSync & sclPrev;
  assign startDet = sclSync & sclPrev & sdaPrev & ~sdaSync;
  assign stopDet  = sclSync & sclPrev & ~sdaPrev & sdaSync;

  // bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bitCnt <= '0;
    else if (ctrl.clrBits)  bitCnt <= '0;
    else if (ctrl.countBit) bitCnt <= bitCnt + 4'd1;
  end
  assign byteDone = (bitCnt == 4'd8);

  // receive shifter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxByte <= '0;
    else if (ctrl.shiftIn) rxByte <= {rxByte[6:0], sdaSync};
  end

  // transmit shifter, MSB first
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             txShift <= 8'hFF;
    else if (ctrl.loadTx)  txShift <= regRdData;
    else if (ctrl.shiftTx) txShift <= {txShift[6:0], 1'b1};
  end
  assign txMsb = txShift[7];

  // persistent location pointer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (ctrl.loadPtr) begin
      ptr <= (rxByte < LOC_LIMIT) ? rxByte[ADDR_W-1:0] : '0;
    end else if (ctrl.incPtr) begin
      ptr <= (ptr == LAST_LOC) ? '0 : ptr + 1'b1;
    end
  end

  // open-drain request, cleared by any bus condition
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   sdaLow <= 1'b0;
    else if (startDet | stopDet) sdaLow <= 1'b0;
    else                         sdaLow <= ctrl.sdaLowNext;
  end

  assign sdaDriveLow = sdaLow;
  assign regAddr     = ptr;
  assign regWrData   = rxByte;
  assign regWrEn     = ctrl.wrEn;

endmodule

// File: rtl/i2c_tgt_ctrl.sv
module i2c_tgt_ctrl
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ID = 7'b1101111
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       byteDone,
  input  logic       sdaSync,
  input  logic [7:0] rxByte,
  input  logic       txMsb,
  output dpCtrl_t    ctrl
);

  busState_e state, stateNext;
  logic      isRead, isReadNext;
  logic      hostAck, hostAckNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isRead  <= 1'b0;
      hostAck <= 1'b0;
    end else begin
      state   <= stateNext;
      isRead  <= isReadNext;
      hostAck <= hostAckNext;
    end
  end

  always_comb begin
    ctrl        = '0;
    stateNext   = state;
    isReadNext  = isRead;
    hostAckNext = hostAck;

    unique case (state)
      ST_DEV, ST_WADDR, ST_WDATA: begin
        if (sclRise && !byteDone) begin
          ctrl.shiftIn  = 1'b1;
          ctrl.countBit = 1'b1;
        end
        if (sclFall && byteDone) begin
          ctrl.clrBits = 1'b1;
          if (state == ST_DEV) begin
            if (rxByte[7:1] == DEV_ID) begin
              isReadNext = rxByte[0];
              stateNext  = ST_DEV_ACK;
            end else begin
              stateNext = ST_WAIT;
            end
          end else if (state == ST_WADDR) begin
            ctrl.loadPtr = 1'b1;
            stateNext    = ST_WADDR_ACK;
          end else begin
            ctrl.wrEn   = 1'b1;
            ctrl.incPtr = 1'b1;
            stateNext   = ST_WDATA_ACK;
          end
        end
      end

      ST_DEV_ACK: begin
        ctrl.sdaLowNext = 1'b1;
        if (sclFall) begin
          ctrl.clrBits = 1'b1;
          if (isRead) begin
            ctrl.loadTx = 1'b1;
            stateNext   = ST_RDATA;
          end else begin
            stateNext = ST_WADDR;
          end
        end
      end

      ST_WADDR_ACK: begin
        ctrl.sdaLowNext = 1'b1;
        if (sclFall) begin
          ctrl.clrBits = 1'b1;
          stateNext    = ST_WDATA;
        end
      end

      ST_WDATA_ACK: begin
        ctrl.sdaLowNext = 1'b1;
        if (sclFall) stateNext = ST_WAIT;
      end

      ST_RDATA: begin
        ctrl.sdaLowNext = ~txMsb;
        if (sclRise && !byteDone) ctrl.countBit = 1'b1;
        if (sclFall && byteDone) begin
          ctrl.clrBits    = 1'b1;
          ctrl.incPtr     = 1'b1;
          ctrl.sdaLowNext = 1'b0;
          stateNext       = ST_RACK;
        end else if (sclFall && bitCnt_nonzero(byteDone)) begin
          ctrl.shiftTx = 1'b1;
        end
      end

      ST_RACK: begin
        if (sclRise) hostAckNext = ~sdaSync;
        if (sclFall) begin
          if (hostAck) begin
            ctrl.loadTx = 1'b1;
            ctrl.clrBits = 1'b1;
            stateNext   = ST_RDATA;
          end else begin
            stateNext = ST_WAIT;
          end
        end
      end

      default: ;  // idle and standby ignore the bus
    endcase

    if (startDet) begin
      ctrl            = '0;
      ctrl.clrBits    = 1'b1;
      stateNext       = ST_DEV;
      hostAckNext     = 1'b0;
    end else if (stopDet) begin
      ctrl            = '0;
      ctrl.clrBits    = 1'b1;
      stateNext       = ST_IDLE;
      hostAckNext     = 1'b0;
    end
  end

  // every falling edge inside a byte that is not its last shifts
  function automatic logic bitCnt_nonzero(input logic done);
    return !done;
  endfunction

endmodule

// File: rtl/i2c_tgt_top.sv
module i2c_tgt_top
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ID      = 7'b1101111,
  parameter int         NUM_REGS    = 26,
  parameter int         SYNC_STAGES = 2,
  localparam int        ADDR_W      = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaDriveLow,
  output logic [ADDR_W-1:0] regAddr,
  output logic [7:0]        regWrData,
  output logic              regWrEn,
  input  logic [7:0]        regRdData
);

  dpCtrl_t    ctrl;
  logic       sclSync, sdaSync, sclRise, sclFall;
  logic       startDet, stopDet, byteDone, txMsb;
  logic [7:0] rxByte;

  i2c_tgt_ctrl #(.DEV_ID(DEV_ID)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet),
    .byteDone(byteDone), .sdaSync(sdaSync),
    .rxByte(rxByte), .txMsb(txMsb),
    .ctrl(ctrl)
  );

  i2c_tgt_datapath #(
    .NUM_REGS(NUM_REGS), .SYNC_STAGES(SYNC_STAGES), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .sclIn(sclIn), .sdaIn(sdaIn),
    .ctrl(ctrl),
    .sclSync(sclSync), .sdaSync(sdaSync),
    .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet),
    .byteDone(byteDone), .rxByte(rxByte), .txMsb(txMsb),
    .sdaDriveLow(sdaDriveLow),
    .regAddr(regAddr), .regWrData(regWrData), .regWrEn(regWrEn),
    .regRdData(regRdData)
  );

endmodule

// File: rtl/i2c_tgt_chk.sv
module i2c_tgt_chk #(
  parameter int NUM_REGS = 26,
  parameter int ADDR_W   = $clog2(NUM_REGS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclSync,
  input logic              stopDet,
  input logic              sdaDriveLow,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWrEn
);

  // R3
  wr_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn);

  // R3
  wr_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |-> !sclSync);

  // R7 R8
  addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    regAddr < ADDR_W'(NUM_REGS));

  // R12
  sda_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(sdaDriveLow) || $fell(sdaDriveLow)) |-> !sclSync);

  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaDriveLow);

endmodule

bind i2c_tgt_top i2c_tgt_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rstN(rstN), .sclSync(sclSync), .stopDet(stopDet),
  .sdaDriveLow(sdaDriveLow), .regAddr(regAddr), .regWrEn(regWrEn)
);

// File: tb/tb_i2c_tgt_top.sv
`timescale 1ns/1ps
module tb_i2c_tgt_top;

  localparam int NREG = 26;
  localparam int Q    = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclM = 1'b1, sdaM = 1'b1;
  logic       sdaDriveLow;
  logic [4:0] regAddr;
  logic [7:0] regWrData, regRdData;
  logic       regWrEn;
  wire        sdaBus = sdaM & ~sdaDriveLow;

  logic [7:0] mem [NREG];
  int nRun = 0, nFail = 0, wrCount = 0;
  bit drvSeen = 1'b0, done = 1'b0;
  int expPtr = 0;

  always #5 clk = ~clk;

  i2c_tgt_top dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .regAddr(regAddr), .regWrData(regWrData),
    .regWrEn(regWrEn), .regRdData(regRdData)
  );

  assign regRdData = (int'(regAddr) < NREG) ? mem[regAddr] : 8'h00;

  always @(posedge clk) begin
    if (regWrEn) begin
      wrCount <= wrCount + 1;
      if (int'(regAddr) < NREG) mem[regAddr] <= regWrData;
    end
    if (sdaDriveLow) drvSeen <= 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; wq(); sclM = 1'b1; wq(); sdaM = 1'b0; wq(); sclM = 1'b0; wq();
  endtask

  task automatic busStop();
    sdaM = 1'b0; wq(); sclM = 1'b1; wq(); sdaM = 1'b1; wq();
  endtask

  task automatic sendBit(input bit b);
    sdaM = b; wq(); sclM = 1'b1; wq(); wq(); sclM = 1'b0; wq();
  endtask

  task automatic sendByte(input logic [7:0] d, output bit acked);
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    sdaM = 1'b1; wq(); sclM = 1'b1; wq();
    acked = (sdaBus == 1'b0);
    wq(); sclM = 1'b0; wq();
  endtask

  task automatic readByte(input bit giveAck, output logic [7:0] d);
    d = '0;
    for (int i = 0; i < 8; i++) begin
      sdaM = 1'b1; wq(); sclM = 1'b1; wq();
      d = {d[6:0], sdaBus};
      wq(); sclM = 1'b0; wq();
    end
    sdaM = giveAck ? 1'b0 : 1'b1; wq(); sclM = 1'b1; wq(); wq();
    sclM = 1'b0; sdaM = 1'b1; wq();
  endtask

  function automatic int nextLoc(input int p);
    return (p == NREG - 1) ? 0 : p + 1;
  endfunction

  // dummy write to set the pointer, then repeated START for read
  task automatic setPtrThenRead(input logic [7:0] wa, input string req);
    bit a;
    busStart();
    sendByte(8'hDE, a); chk(a, {req, " id write ack"}, a, 1);
    sendByte(wa, a);    chk(a, {req, " word address ack"}, a, 1);
    busStart();
    sendByte(8'hDF, a); chk(a, {req, " id read ack"}, a, 1);
  endtask

  task automatic testReset();
    chk(!sdaDriveLow, "R12 released after reset", sdaDriveLow, 0);
    chk(!regWrEn, "R12 no store after reset", regWrEn, 0);
  endtask

  task automatic testCurrentAfterReset();
    bit a; logic [7:0] d;
    busStart();
    sendByte(8'hDF, a);
    chk(a, "R1 identifier 1101111 read acknowledged", a, 1);
    readByte(1'b0, d);
    busStop();
    chk(d == mem[0], "R5 read after reset from 00h", d, mem[0]);
    expPtr = 1;
  endtask

  task automatic testWrite();
    bit a; int w0; logic [7:0] before6;
    w0 = wrCount; before6 = mem[6];
    busStart();
    sendByte(8'hDE, a); chk(a, "R1 identifier write ack", a, 1);
    sendByte(8'h05, a); chk(a, "R3 word address ack", a, 1);
    sendByte(8'h3C, a); chk(a, "R3 data byte ack", a, 1);
    sendByte(8'h99, a); chk(!a, "R3 extra byte not acknowledged", a, 0);
    busStop();
    chk(mem[5] == 8'h3C, "R3 byte stored at 05h", mem[5], 8'h3C);
    chk(mem[6] == before6, "R3 extra byte not stored", mem[6], before6);
    chk(wrCount - w0 == 1, "R3 single store pulse", wrCount - w0, 1);
    expPtr = 6;
  endtask

  task automatic testReadAfterWrite();
    bit a; logic [7:0] d;
    busStart();
    sendByte(8'hDF, a);
    readByte(1'b0, d);
    busStop();
    chk(d == mem[expPtr], "R9 current read after write at next location", d, mem[expPtr]);
    expPtr = nextLoc(expPtr);
  endtask

  task automatic testRandomStream();
    logic [7:0] d;
    setPtrThenRead(8'h0A, "R4");
    for (int k = 0; k < 3; k++) begin
      readByte(k != 2, d);
      chk(d == mem[10 + k], "R4 R6 streamed byte MSB first", d, mem[10 + k]);
    end
    busStop();
    expPtr = 13;
  endtask

  task automatic testWrap();
    logic [7:0] d;
    int loc;
    loc = 24;
    setPtrThenRead(8'h18, "R7");
    for (int k = 0; k < 3; k++) begin
      readByte(k != 2, d);
      chk(d == mem[loc], "R7 pointer wraps 19h to 00h", d, mem[loc]);
      loc = nextLoc(loc);
    end
    busStop();
    expPtr = loc;
  endtask

  task automatic testOutOfRange();
    logic [7:0] d;
    setPtrThenRead(8'h40, "R8");
    readByte(1'b0, d);
    busStop();
    chk(d == mem[0], "R8 address 40h maps to 00h", d, mem[0]);
    expPtr = 1;
  endtask

  task automatic testMismatch();
    bit a; int w0; logic [7:0] m3;
    w0 = wrCount; m3 = mem[3];
    drvSeen = 1'b0;
    busStart();
    sendByte(8'hAE, a); chk(!a, "R2 wrong identifier not acknowledged", a, 0);
    sendByte(8'h03, a); chk(!a, "R2 later byte ignored", a, 0);
    sendByte(8'h55, a); chk(!a, "R2 later byte ignored", a, 0);
    busStop();
    chk(!drvSeen, "R2 line never pulled", drvSeen, 0);
    chk(wrCount == w0 && mem[3] == m3, "R2 nothing stored", wrCount - w0, 0);
  endtask

  task automatic testNackRelease();
    logic [7:0] d; bit lvl;
    setPtrThenRead(8'h03, "R10");
    readByte(1'b0, d);
    chk(d == mem[3], "R10 byte before NACK", d, mem[3]);
    drvSeen = 1'b0;
    sdaM = 1'b1; wq(); sclM = 1'b1; wq();
    lvl = sdaBus;
    wq(); sclM = 1'b0; wq();
    chk(lvl && !drvSeen, "R10 line released after NACK", lvl, 1);
    busStop();
    busStart();
    sendByte(8'hDF, lvl);
    readByte(1'b0, d);
    busStop();
    chk(d == mem[4], "R10 next read continues at 04h", d, mem[4]);
  endtask

  task automatic testStartAbort();
    bit a; int w0; logic [7:0] d;
    w0 = wrCount;
    busStart();
    sendByte(8'hDE, a);
    sendByte(8'h02, a);
    sendBit(1'b1); sendBit(1'b0); sendBit(1'b1); sendBit(1'b0);
    busStart();
    sendByte(8'hDF, a);
    chk(a, "R11 identifier after repeated START acknowledged", a, 1);
    readByte(1'b0, d);
    busStop();
    chk(d == mem[2], "R11 aborted byte left pointer at 02h", d, mem[2]);
    chk(wrCount == w0, "R11 aborted byte not stored", wrCount - w0, 0);
    chk(!sdaDriveLow, "R11 released after STOP", sdaDriveLow, 0);
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) mem[i] = 8'(i * 37 + 11);
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    testReset();
    testCurrentAfterReset();
    testWrite();
    testReadAfterWrite();
    testRandomStream();
    testWrap();
    testOutOfRange();
    testMismatch();
    testNackRelease();
    testStartAbort();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nRun++; nFail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule